// File: doc/BRIEF.md
# Programmable-phase divided clock generator

This block turns one fast input clock into three slower timing waves. All three come from a single free-running phase counter that advances on every input clock. The first wave is an ADC sample clock at one eighth of the input rate. The second is a sensor clock at one quarter of the input rate. The third is an odd/even select clock, also at one eighth of the input rate. Every output is a flop clocked by the input clock, so the three waves keep a fixed relation to one another and are free of combinational glitches.

An 8-bit configuration word sets where two of the waves sit relative to the ADC clock's falling edge, in whole input-clock steps. Its low nibble sets the rising edge of the sensor clock. Its high nibble sets the falling edge of the select clock. Each nibble is a 4-bit code folded modulo eight, so a code that asks for an advance behaves the same as the matching delay. A word written through the strobed write port is held as pending. It goes live only when the phase counter wraps back to zero, so the waves change phase only at the start of an ADC period.

Top module: `phase_clkgen`

## Requirements
- R1: `adc_clk_o` has a period of 8 input clocks. It is low for phase counts 0 to 3 and high for counts 4 to 7. Its falling edge marks the counter's wrap from 7 to 0, and the counter is 0 in the first cycle after reset is released.
- R2: `sen_clk_o` has a period of 4 input clocks. With sensor offset S, it rises when the phase count equals S and again at (S+4) mod 8. It stays high for exactly 2 steps after each rising edge.
- R3: `sel_clk_o` has a period of 8 input clocks. With select offset Q, it falls when the phase count equals Q and rises 4 steps later.
- R4: Code to offset mapping. Bits 3:0 of the configuration word are the sensor code and bits 7:4 are the select code. A code with bit 3 clear gives an offset equal to bits 2:0 (0 to 7 steps of delay). A code with bit 3 set gives an offset of (8 − bits 2:0) mod 8. So 1000 acts as 0000, 1001 acts as 0111, and 1111 acts as 0001.
- R5: A word written while `cfg_we_i` is high is captured at that clock edge. It takes effect from the cycle in which the phase count is 0. Until then the outputs keep the previous offsets. A write on the edge that moves the count from 7 to 0 takes effect at once.
- R6: While reset is asserted and in the first cycle after it is released, the sensor code is 0000 and the select code is 1100. `adc_clk_o` is 0, `sen_clk_o` is 1 and `sel_clk_o` is 1.
- R7: When several writes arrive before a wrap, only the last one written takes effect at the wrap.
- R8: While `cfg_we_i` is low, `cfg_wdata_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 8 | Configuration word: [3:0] sensor code, [7:4] select code |
| adc_clk_o | output | 1 | ADC sample clock, input rate / 8 |
| sen_clk_o | output | 1 | Sensor clock, input rate / 4 |
| sel_clk_o | output | 1 | Odd/even select clock, input rate / 8 |

## Verification
Two behaviours hold no matter what is configured, and the assertions check them on every cycle. The first is the ADC clock's fixed rhythm of four low steps and four high steps. The second is the set of output levels seen on the first edge after reset. The placement of the sensor and select edges depends on offsets held inside the block, and a mid-stream phase change can legally shorten one pulse, so these are shown only by the bench's scenarios. The bench tracks the pending and live codes and compares every output on every cycle. The scenarios sweep all sixteen codes of each nibble, including the aliasing ones, and place writes at different phase counts, including the wrap edge itself. They also cover back-to-back writes, idle data on the write port, and a long run of random writes.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

   // Which flavour of lane to build: a lane locked to phase zero, or one
   // whose phase follows a folded code.
   typedef enum logic {
      LANE_FIXED   = 1'b0,
      LANE_SHIFTED = 1'b1
   } lane_kind_e;

   // Fold a signed-looking code of pw+1 bits into an offset modulo 2**pw.
   function automatic int fold_code(input int code, input int pw);
      int modulus;
      int low;
      modulus = 1 << pw;
      low     = code % modulus;
      if (((code >> pw) & 1) != 0) begin
         return (modulus - low) % modulus;
      end
      return low;
   endfunction

   // Level of a lane when the phase counter sits at cnt.
   function automatic logic lane_level(input int cnt, input int code, input int pw,
                                       input int tap, input logic inv);
      int modulus;
      int diff;
      modulus = 1 << pw;
      diff    = (cnt - fold_code(code, pw) + modulus) % modulus;
      return logic'(((diff >> tap) & 1) != 0) ^ inv;
   endfunction

endpackage

// File: rtl/pclk_phase_cnt.sv
module pclk_phase_cnt #(
   parameter int unsigned PHASE_W = 3
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   output logic [PHASE_W-1:0] cnt_nxt_o,
   output logic               wrap_nxt_o
);

   logic [PHASE_W-1:0] cnt_q;

   assign cnt_nxt_o  = cnt_q + 1'b1;
   assign wrap_nxt_o = (cnt_nxt_o == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_nxt_o;
      end
   end

endmodule

// File: rtl/pclk_cfg_stage.sv
module pclk_cfg_stage #(
   parameter int unsigned         PHASE_W      = 3,
   parameter logic [PHASE_W:0]    SEN_RST_CODE = '0,
   parameter logic [PHASE_W:0]    SEL_RST_CODE = '0
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   we_i,
   input  logic [2*PHASE_W+1:0]   wdata_i,
   input  logic                   wrap_nxt_i,
   output logic [PHASE_W:0]       sen_code_nxt_o,
   output logic [PHASE_W:0]       sel_code_nxt_o
);

   localparam int unsigned CODE_W = PHASE_W + 1;

   logic [CODE_W-1:0] sen_pend_q, sel_pend_q;
   logic [CODE_W-1:0] sen_pend_d, sel_pend_d;
   logic [CODE_W-1:0] sen_live_q, sel_live_q;

   // A write lands in the pending copy at once; the live copy follows
   // only on the edge that brings the counter back to zero.
   assign sen_pend_d = we_i ? wdata_i[CODE_W-1:0]        : sen_pend_q;
   assign sel_pend_d = we_i ? wdata_i[2*CODE_W-1:CODE_W] : sel_pend_q;

   assign sen_code_nxt_o = wrap_nxt_i ? sen_pend_d : sen_live_q;
   assign sel_code_nxt_o = wrap_nxt_i ? sel_pend_d : sel_live_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sen_pend_q <= SEN_RST_CODE;
         sel_pend_q <= SEL_RST_CODE;
         sen_live_q <= SEN_RST_CODE;
         sel_live_q <= SEL_RST_CODE;
      end else begin
         sen_pend_q <= sen_pend_d;
         sel_pend_q <= sel_pend_d;
         sen_live_q <= sen_code_nxt_o;
         sel_live_q <= sel_code_nxt_o;
      end
   end

endmodule

// File: rtl/pclk_lane.sv
module pclk_lane #(
   parameter int unsigned          PHASE_W   = 3,
   parameter pclk_pkg::lane_kind_e KIND      = pclk_pkg::LANE_SHIFTED,
   parameter int unsigned          TAP       = 2,
   parameter logic                 INV       = 1'b0,
   parameter logic                 RST_LEVEL = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [PHASE_W-1:0] cnt_nxt_i,
   input  logic [PHASE_W:0]   code_nxt_i,
   output logic               wave_o
);

   logic [PHASE_W-1:0] off;
   logic [PHASE_W-1:0] diff;
   logic               level;
   logic               wave_q;

   generate
      if (TAP >= PHASE_W) begin : g_bad_tap
         $error("pclk_lane: TAP must index a bit of the phase counter");
      end
      if (KIND == pclk_pkg::LANE_FIXED) begin : g_fixed
         logic unused_code;
         assign unused_code = ^code_nxt_i;
         assign off         = '0;
      end else begin : g_shifted
         logic [PHASE_W-1:0] mag;
         assign mag = code_nxt_i[PHASE_W-1:0];
         // A set top bit means an advance; an advance of m equals a delay of
         // (modulus - m), which is the two's complement of m in PHASE_W bits.
         assign off = code_nxt_i[PHASE_W] ? ('0 - mag) : mag;
      end
   endgenerate

   assign diff  = cnt_nxt_i - off;
   assign level = diff[TAP] ^ INV;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wave_q <= RST_LEVEL;
      end else begin
         wave_q <= level;
      end
   end

   assign wave_o = wave_q;

endmodule

// File: rtl/phase_clkgen.sv
module phase_clkgen #(
   parameter int unsigned PHASE_W      = 3,
   parameter logic [3:0]  SEN_RST_CODE = 4'b0000,
   parameter logic [3:0]  SEL_RST_CODE = 4'b1100
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       cfg_we_i,
   input  logic [7:0] cfg_wdata_i,
   output logic       adc_clk_o,
   output logic       sen_clk_o,
   output logic       sel_clk_o
);

   localparam int unsigned CODE_W  = PHASE_W + 1;
   localparam int unsigned CFG_W   = 2 * CODE_W;
   localparam int unsigned SLOW_TAP = PHASE_W - 1;
   localparam int unsigned FAST_TAP = PHASE_W - 2;

   localparam logic ADC_RST_LVL =
      pclk_pkg::lane_level(0, 0, int'(PHASE_W), int'(SLOW_TAP), 1'b0);
   localparam logic SEN_RST_LVL =
      pclk_pkg::lane_level(0, int'(SEN_RST_CODE), int'(PHASE_W), int'(FAST_TAP), 1'b1);
   localparam logic SEL_RST_LVL =
      pclk_pkg::lane_level(0, int'(SEL_RST_CODE), int'(PHASE_W), int'(SLOW_TAP), 1'b0);

   generate
      if (PHASE_W != 3) begin : g_bad_width
         $error("phase_clkgen: the 8-bit configuration word needs PHASE_W == 3");
      end
      if (CFG_W != 8) begin : g_bad_cfg
         $error("phase_clkgen: configuration word width mismatch");
      end
   endgenerate

   logic [PHASE_W-1:0] cnt_nxt;
   logic               wrap_nxt;
   logic [CODE_W-1:0]  sen_code_nxt;
   logic [CODE_W-1:0]  sel_code_nxt;

   pclk_phase_cnt #(
      .PHASE_W   (PHASE_W)
   ) i_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_nxt_o (cnt_nxt),
      .wrap_nxt_o(wrap_nxt)
   );

   pclk_cfg_stage #(
      .PHASE_W       (PHASE_W),
      .SEN_RST_CODE  (SEN_RST_CODE),
      .SEL_RST_CODE  (SEL_RST_CODE)
   ) i_cfg (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .we_i          (cfg_we_i),
      .wdata_i       (cfg_wdata_i),
      .wrap_nxt_i    (wrap_nxt),
      .sen_code_nxt_o(sen_code_nxt),
      .sel_code_nxt_o(sel_code_nxt)
   );

   pclk_lane #(
      .PHASE_W  (PHASE_W),
      .KIND     (pclk_pkg::LANE_FIXED),
      .TAP      (SLOW_TAP),
      .INV      (1'b0),
      .RST_LEVEL(ADC_RST_LVL)
   ) i_adc_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_nxt_i (cnt_nxt),
      .code_nxt_i('0),
      .wave_o    (adc_clk_o)
   );

   pclk_lane #(
      .PHASE_W  (PHASE_W),
      .KIND     (pclk_pkg::LANE_SHIFTED),
      .TAP      (FAST_TAP),
      .INV      (1'b1),
      .RST_LEVEL(SEN_RST_LVL)
   ) i_sen_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_nxt_i (cnt_nxt),
      .code_nxt_i(sen_code_nxt),
      .wave_o    (sen_clk_o)
   );

   pclk_lane #(
      .PHASE_W  (PHASE_W),
      .KIND     (pclk_pkg::LANE_SHIFTED),
      .TAP      (SLOW_TAP),
      .INV      (1'b0),
      .RST_LEVEL(SEL_RST_LVL)
   ) i_sel_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_nxt_i (cnt_nxt),
      .code_nxt_i(sel_code_nxt),
      .wave_o    (sel_clk_o)
   );

endmodule

// File: rtl/phase_clkgen_chk.sv
module phase_clkgen_chk #(
   parameter int unsigned PHASE_W     = 3,
   parameter logic        ADC_RST_LVL = 1'b0,
   parameter logic        SEN_RST_LVL = 1'b1,
   parameter logic        SEL_RST_LVL = 1'b1
) (
   input logic clk_i,
   input logic rst_ni,
   input logic adc_clk_i,
   input logic sen_clk_i,
   input logic sel_clk_i
);

   localparam int unsigned HALF = 1 << (PHASE_W - 1);

   // Length of the current ADC level run, kept by the checker itself.
   logic [PHASE_W-1:0] run_q;
   logic               adc_prev_q;
   logic               adc_same;

   assign adc_same = (adc_clk_i == adc_prev_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q      <= '0;
         adc_prev_q <= ADC_RST_LVL;
      end else begin
         adc_prev_q <= adc_clk_i;
         run_q      <= adc_same ? run_q + 1'b1 : '0;
      end
   end

   AST_ADC_HIGH_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(adc_clk_i) |=> adc_clk_i); // R1

   AST_ADC_LOW_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(adc_clk_i) |=> !adc_clk_i); // R1

   AST_ADC_RUN_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adc_same |-> (run_q < PHASE_W'(HALF))); // R1

   AST_RESET_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (adc_clk_i == ADC_RST_LVL && sen_clk_i == SEN_RST_LVL
                         && sel_clk_i == SEL_RST_LVL)); // R6

endmodule

bind phase_clkgen phase_clkgen_chk #(
   .PHASE_W    (PHASE_W),
   .ADC_RST_LVL(ADC_RST_LVL),
   .SEN_RST_LVL(SEN_RST_LVL),
   .SEL_RST_LVL(SEL_RST_LVL)
) i_phase_clkgen_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .adc_clk_i(adc_clk_o),
   .sen_clk_i(sen_clk_o),
   .sel_clk_i(sel_clk_o)
);

// File: tb/test_phase_clkgen.sv
module test_phase_clkgen;

   logic       clk = 1'b0;
   logic       rst_ni = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic       adc_clk, sen_clk, sel_clk;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // Bench model of the phase counter and the pending / live codes.
   int m_cnt;
   int m_pend;
   int m_live;

   always #10 clk = ~clk;

   phase_clkgen i_phase_clkgen (
      .clk_i      (clk),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we),
      .cfg_wdata_i(cfg_wdata),
      .adc_clk_o  (adc_clk),
      .sen_clk_o  (sen_clk),
      .sel_clk_o  (sel_clk)
   );

   function automatic int fold(input int code);
      int low;
      low = code & 7;
      return ((code & 8) != 0) ? ((8 - low) & 7) : low;
   endfunction

   function automatic logic exp_adc(input int cnt);
      return logic'(cnt >= 4);
   endfunction

   function automatic logic exp_sen(input int cnt, input int code);
      return logic'(((cnt - fold(code)) & 3) < 2);
   endfunction

   function automatic logic exp_sel(input int cnt, input int code);
      return logic'(((cnt - fold(code)) & 7) >= 4);
   endfunction

   task automatic check_bit(input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%b expected=%b (count=%0d live=%h)",
                  what, act, exp, m_cnt, m_live[7:0]);
      end
   endtask

   task automatic check_all(input string tag);
      check_bit({"R1 adc ", tag}, adc_clk, exp_adc(m_cnt));
      check_bit({"R2 sen ", tag}, sen_clk, exp_sen(m_cnt, m_live & 15));
      check_bit({"R3 sel ", tag}, sel_clk, exp_sel(m_cnt, (m_live >> 4) & 15));
   endtask

   // Drive at a falling edge, advance one rising edge, check at the next fall.
   task automatic step(input logic we, input logic [7:0] wd, input string tag);
      cfg_we    = we;
      cfg_wdata = wd;
      @(posedge clk);
      if (we) m_pend = int'(wd);
      if (m_cnt == 7) m_live = m_pend;
      m_cnt = (m_cnt + 1) & 7;
      @(negedge clk);
      cfg_we    = 1'b0;
      cfg_wdata = 8'($urandom);
      check_all(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, tag);
   endtask

   task automatic goto_count(input int target, input string tag);
      while (((m_cnt + 1) & 7) != target) step(1'b0, 8'h00, tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      m_cnt  = 0;
      m_pend = 8'hC0;
      m_live = 8'hC0;
      repeat (3) @(negedge clk);
      // R6: levels during reset
      check_bit("R6 adc in reset", adc_clk, 1'b0);
      check_bit("R6 sen in reset", sen_clk, 1'b1);
      check_bit("R6 sel in reset", sel_clk, 1'b1);
      rst_ni = 1'b1;
      #1;
      check_all("R6 first cycle after reset");
      @(negedge clk);
      // The first edge after release moves the counter to 1.
      m_cnt = 1;
      check_all("R6 default codes");
      idle(16, "R6 default codes running");

      // R4: every sensor code and every select code, incl. aliases
      for (int c = 0; c < 16; c++) begin
         goto_count(c & 7, "R4 sweep");
         step(1'b1, 8'((((15 - c) & 15) << 4) | c), "R4 sweep write");
         idle(12, "R4 sweep");
      end

      // R4: alias pairs 1001/0111, 1111/0001 and 1000/0000
      step(1'b1, 8'h79, "R4 alias");
      idle(10, "R4 alias 1001 vs 0111");
      step(1'b1, 8'hF1, "R4 alias");
      idle(10, "R4 alias 1111 vs 0001");
      step(1'b1, 8'h08, "R4 alias");
      idle(10, "R4 alias 1000 vs 0000");

      // R5: write mid-period keeps old phase until the wrap
      goto_count(2, "R5 setup");
      step(1'b1, 8'h53, "R5 write at count 2");
      idle(14, "R5 deferred apply");
      // R5: write on the wrap edge takes effect at once
      goto_count(0, "R5 setup");
      step(1'b1, 8'h26, "R5 write on wrap edge");
      idle(10, "R5 immediate apply");

      // R7: last of several writes before a wrap wins
      goto_count(1, "R7 setup");
      step(1'b1, 8'h11, "R7 first write");
      step(1'b1, 8'h4C, "R7 second write");
      step(1'b1, 8'hA5, "R7 last write");
      idle(12, "R7 last write wins");

      // R8: data without strobe is ignored
      for (int i = 0; i < 24; i++) step(1'b0, 8'($urandom), "R8 no strobe");

      // Random writes at random counts
      for (int i = 0; i < 1500; i++) begin
         logic we;
         we = (($urandom % 8) == 0);
         step(we, 8'($urandom), "R2/R3/R5 random");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all): actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule